// File: doc/BRIEF.md
# Radio Frame Control Sequencer

This block drives the control strobes of an external frequency-hopping radio transceiver through each time-division-duplex slot. The baseband tells it when a transmit frame or a receive frame is in progress, and when a sync-word search (correlation) starts and ends. From these indications it releases the transmitter or the receiver power-down, opens the synthesizer loop where needed, sets the antenna switch, and gates the radio chip enable and the reference oscillator. During a correlation it also produces a timed profile on three active-low DC-compensation enables.

The sequencer stays idle after reset until it sees a low-to-high transition on the system-load input. A low level on system-load forces it back to idle at any time. All outputs are registered, so each one follows its inputs by one clock. The DC-compensation timing assumes an 8 MHz clock. At that rate the 15 µs settling window is 120 cycles and the pulsed enable has a 1 µs period of 8 cycles. Both are parameters.

Top module: `radio_frame_seq`

## Requirements
- R1: After reset the block is idle: chip_en=0, ref_osc_en=0, tx_pd=1, rx_pd=1, pll_pd=1, ant_sw=0 and all three DC-compensation enables are 1. A system-load input that is already high when reset is released does not start it. While idle, frame and correlation indications have no effect.
- R2: A 0-to-1 transition on sys_load makes the block active, and chip_en and ref_osc_en read 1 two clocks after the first high sample. Whenever sys_load is sampled low, the block returns to idle and the outputs return to their R1 values two clocks later.
- R3: dcc_hold_n is 0 from the clock after corr_start is sampled (while active) until the clock after corr_end is sampled.
- R4: dcc_lead_n is 0 for the first SOLID_CYCLES (120) cycles of a correlation and 1 afterwards.
- R5: dcc_pwm_n is 0 for the first 120 cycles of a correlation. After that it is 0 for one cycle out of every 8, starting at cycle 120 of the correlation (cycle 0 is the first low cycle of dcc_hold_n).
- R6: When corr_end is sampled, or when the block goes idle, all three DC-compensation enables read 1 on the next clock. If corr_end and corr_start arrive together, the end wins. A corr_start during a running correlation or while idle is ignored.
- R7: tx_pd is 0 only while active with tx_frame sampled 1, one clock after the sample.
- R8: rx_pd is 0 only while active with rx_frame=1 and tx_frame=0. When both frame requests are present, transmit wins.
- R9: pll_pd is 1 during a transmit frame and while idle. During a receive frame it equals cfg_pll_open_rx. While active with no frame it is 0.
- R10: ant_sw is 1 exactly when tx_pd is 0, and ant_sw_n is always the inverse of ant_sw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_load | input | 1 | System-load; rising edge activates, low level forces idle |
| cfg_pll_open_rx | input | 1 | Configuration bit: open the PLL loop during receive |
| tx_frame | input | 1 | Transmit frame in progress |
| rx_frame | input | 1 | Receive frame in progress |
| corr_start | input | 1 | Correlation phase start strobe |
| corr_end | input | 1 | Correlation phase end strobe |
| dcc_hold_n | output | 1 | DC-compensation enable, low for the whole correlation |
| dcc_pwm_n | output | 1 | DC-compensation enable, solid then 1-of-8 pulsed |
| dcc_lead_n | output | 1 | DC-compensation enable, low for the settling window only |
| tx_pd | output | 1 | Transmitter power-down |
| rx_pd | output | 1 | Receiver power-down |
| pll_pd | output | 1 | PLL power-down / loop open |
| chip_en | output | 1 | Radio chip enable |
| ref_osc_en | output | 1 | Reference oscillator gate |
| ant_sw | output | 1 | Antenna switch control, 1 selects transmit |
| ant_sw_n | output | 1 | Inverse of ant_sw |

## Verification
The assertions check relations that hold on every cycle. The settling and pulsed enables are never low unless the whole-phase enable is low. A sampled correlation end releases all three enables. A transmit and a receive release never occur together. A transmit release always comes with an open loop and the antenna on the transmit side. A checker counter bounds the settling window at 120 cycles. Only the bench scenarios can show the exact cycle counts of the 15 µs window and the 1-of-8 phase. They also cover the rising-edge start rule across reset, the ignored restarts, transmit priority and the receive-mode loop option.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_RX   = 2'd2,
    PH_TX   = 2'd3
  } rfs_phase_e;

  typedef struct packed {
    logic tx_pd;
    logic rx_pd;
    logic pll_pd;
    logic chip_en;
    logic osc_en;
    logic ant_sw;
  } rfs_pwr_t;

  localparam rfs_pwr_t PWR_IDLE = '{tx_pd: 1'b1, rx_pd: 1'b1, pll_pd: 1'b1,
                                    chip_en: 1'b0, osc_en: 1'b0, ant_sw: 1'b0};

endpackage

// File: rtl/rfs_mode_ctrl.sv
module rfs_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_load,
  output logic active
);

  logic load_q;
  logic active_q;
  logic active_d;

  always_comb begin
    // a new activation needs a low-to-high step; a low level always drops out
    active_d = sys_load & (active_q | ~load_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= 1'b1;
      active_q <= 1'b0;
    end else begin
      load_q   <= sys_load;
      active_q <= active_d;
    end
  end

  assign active = active_q;

endmodule

// File: rtl/rfs_power_ctrl.sv
module rfs_power_ctrl
  import rfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tx_frame,
  input  logic rx_frame,
  input  logic pll_open_rx,
  output logic tx_pd,
  output logic rx_pd,
  output logic pll_pd,
  output logic chip_en,
  output logic osc_en,
  output logic ant_sw
);

  rfs_phase_e phase;
  rfs_pwr_t   pwr_d;
  rfs_pwr_t   pwr_q;

  always_comb begin
    if (!active)       phase = PH_IDLE;
    else if (tx_frame) phase = PH_TX;
    else if (rx_frame) phase = PH_RX;
    else               phase = PH_ON;
  end

  always_comb begin
    pwr_d = PWR_IDLE;
    case (phase)
      PH_ON: begin
        pwr_d.chip_en = 1'b1;
        pwr_d.osc_en  = 1'b1;
        pwr_d.pll_pd  = 1'b0;
      end
      PH_RX: begin
        pwr_d.chip_en = 1'b1;
        pwr_d.osc_en  = 1'b1;
        pwr_d.rx_pd   = 1'b0;
        pwr_d.pll_pd  = pll_open_rx;
      end
      PH_TX: begin
        pwr_d.chip_en = 1'b1;
        pwr_d.osc_en  = 1'b1;
        pwr_d.tx_pd   = 1'b0;
        pwr_d.pll_pd  = 1'b1;
        pwr_d.ant_sw  = 1'b1;
      end
      default: pwr_d = PWR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= PWR_IDLE;
    else        pwr_q <= pwr_d;
  end

  assign tx_pd   = pwr_q.tx_pd;
  assign rx_pd   = pwr_q.rx_pd;
  assign pll_pd  = pwr_q.pll_pd;
  assign chip_en = pwr_q.chip_en;
  assign osc_en  = pwr_q.osc_en;
  assign ant_sw  = pwr_q.ant_sw;

endmodule

// File: rtl/rfs_dccomp.sv
module rfs_dccomp #(
  parameter int SOLID_CYCLES = 120,
  parameter int PWM_PERIOD   = 8,
  parameter int PWM_LOW      = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic corr_start,
  input  logic corr_end,
  output logic hold_n,
  output logic pwm_n,
  output logic lead_n
);

  localparam int LEAD_W = $clog2(SOLID_CYCLES + 1);
  localparam int PWM_W  = (PWM_PERIOD > 2) ? $clog2(PWM_PERIOD) : 1;
  localparam logic [LEAD_W-1:0] LEAD_MAX = LEAD_W'(SOLID_CYCLES);
  localparam logic [PWM_W-1:0]  PWM_LAST = PWM_W'(PWM_PERIOD - 1);
  localparam logic [PWM_W-1:0]  PWM_LIM  = PWM_W'(PWM_LOW);

  logic              on_q, on_d;
  logic [LEAD_W-1:0] lead_q, lead_d;
  logic [PWM_W-1:0]  pcnt_q, pcnt_d;
  logic              in_lead_d;
  logic              hold_n_q, pwm_n_q, lead_n_q;
  logic              hold_n_d, pwm_n_d, lead_n_d;
  logic              cnt_en;

  assign cnt_en = on_q;

  always_comb begin
    on_d   = on_q;
    lead_d = lead_q;
    pcnt_d = pcnt_q;
    if (!active || corr_end) begin
      on_d = 1'b0;
    end else if (!on_q && corr_start) begin
      on_d   = 1'b1;
      lead_d = '0;
      pcnt_d = '0;
    end else if (cnt_en) begin
      if (lead_q < LEAD_MAX) lead_d = lead_q + 1'b1;
      else if (pcnt_q == PWM_LAST) pcnt_d = '0;
      else pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_comb begin
    in_lead_d = lead_d < LEAD_MAX;
    hold_n_d  = ~on_d;
    lead_n_d  = ~(on_d & in_lead_d);
    pwm_n_d   = ~(on_d & (in_lead_d | (pcnt_d < PWM_LIM)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q     <= 1'b0;
      lead_q   <= '0;
      pcnt_q   <= '0;
      hold_n_q <= 1'b1;
      pwm_n_q  <= 1'b1;
      lead_n_q <= 1'b1;
    end else begin
      on_q     <= on_d;
      lead_q   <= lead_d;
      pcnt_q   <= pcnt_d;
      hold_n_q <= hold_n_d;
      pwm_n_q  <= pwm_n_d;
      lead_n_q <= lead_n_d;
    end
  end

  assign hold_n = hold_n_q;
  assign pwm_n  = pwm_n_q;
  assign lead_n = lead_n_q;

endmodule

// File: rtl/radio_frame_seq.sv
module radio_frame_seq #(
  parameter int SOLID_CYCLES = 120,
  parameter int PWM_PERIOD   = 8,
  parameter int PWM_LOW      = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_load,
  input  logic cfg_pll_open_rx,
  input  logic tx_frame,
  input  logic rx_frame,
  input  logic corr_start,
  input  logic corr_end,
  output logic dcc_hold_n,
  output logic dcc_pwm_n,
  output logic dcc_lead_n,
  output logic tx_pd,
  output logic rx_pd,
  output logic pll_pd,
  output logic chip_en,
  output logic ref_osc_en,
  output logic ant_sw,
  output logic ant_sw_n
);

  logic rst_meta;
  logic rst_sync_n;
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  rfs_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sys_load (sys_load),
    .active   (active)
  );

  rfs_power_ctrl u_power (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .active      (active),
    .tx_frame    (tx_frame),
    .rx_frame    (rx_frame),
    .pll_open_rx (cfg_pll_open_rx),
    .tx_pd       (tx_pd),
    .rx_pd       (rx_pd),
    .pll_pd      (pll_pd),
    .chip_en     (chip_en),
    .osc_en      (ref_osc_en),
    .ant_sw      (ant_sw)
  );

  rfs_dccomp #(
    .SOLID_CYCLES (SOLID_CYCLES),
    .PWM_PERIOD   (PWM_PERIOD),
    .PWM_LOW      (PWM_LOW)
  ) u_dcc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .active     (active),
    .corr_start (corr_start),
    .corr_end   (corr_end),
    .hold_n     (dcc_hold_n),
    .pwm_n      (dcc_pwm_n),
    .lead_n     (dcc_lead_n)
  );

  assign ant_sw_n = ~ant_sw;

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int SOLID_CYCLES = 120
) (
  input logic clk,
  input logic rst_n,
  input logic sys_load,
  input logic corr_end,
  input logic dcc_hold_n,
  input logic dcc_pwm_n,
  input logic dcc_lead_n,
  input logic tx_pd,
  input logic rx_pd,
  input logic pll_pd,
  input logic chip_en,
  input logic ant_sw
);

  localparam int RUN_W = $clog2(SOLID_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] lead_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lead_run <= '0;
    else if (dcc_lead_n) lead_run <= '0;
    else if (lead_run != RUN_MAX) lead_run <= lead_run + 1'b1;
  end

  p_lead_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dcc_lead_n |-> !dcc_hold_n);

  p_lead_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lead_run <= RUN_W'(SOLID_CYCLES));

  p_pwm_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dcc_pwm_n |-> !dcc_hold_n);

  p_end_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    corr_end |=> (dcc_hold_n && dcc_pwm_n && dcc_lead_n));

  p_idle_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sys_load, 2) |-> !chip_en);

  p_tx_needs_chip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pd |-> chip_en);

  p_tx_rx_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pd |-> rx_pd);

  p_tx_loop_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pd |-> pll_pd);

  p_ant_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ant_sw |-> (!tx_pd && rx_pd));

endmodule

bind radio_frame_seq rfs_checker #(
  .SOLID_CYCLES (SOLID_CYCLES)
) u_rfs_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sys_load   (sys_load),
  .corr_end   (corr_end),
  .dcc_hold_n (dcc_hold_n),
  .dcc_pwm_n  (dcc_pwm_n),
  .dcc_lead_n (dcc_lead_n),
  .tx_pd      (tx_pd),
  .rx_pd      (rx_pd),
  .pll_pd     (pll_pd),
  .chip_en    (chip_en),
  .ant_sw     (ant_sw)
);

// File: tb/test_radio_frame_seq.sv
`timescale 1ns/1ps
module test_radio_frame_seq;

  logic clk = 1'b0;
  logic rst_n;
  logic sys_load, cfg_pll_open_rx, tx_frame, rx_frame, corr_start, corr_end;
  logic dcc_hold_n, dcc_pwm_n, dcc_lead_n, tx_pd, rx_pd, pll_pd;
  logic chip_en, ref_osc_en, ant_sw, ant_sw_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  radio_frame_seq i_radio_frame_seq (
    .clk (clk), .rst_n (rst_n), .sys_load (sys_load),
    .cfg_pll_open_rx (cfg_pll_open_rx), .tx_frame (tx_frame), .rx_frame (rx_frame),
    .corr_start (corr_start), .corr_end (corr_end),
    .dcc_hold_n (dcc_hold_n), .dcc_pwm_n (dcc_pwm_n), .dcc_lead_n (dcc_lead_n),
    .tx_pd (tx_pd), .rx_pd (rx_pd), .pll_pd (pll_pd), .chip_en (chip_en),
    .ref_osc_en (ref_osc_en), .ant_sw (ant_sw), .ant_sw_n (ant_sw_n)
  );

  // behavioural reference model
  bit m_act, m_slq, m_corr;
  int m_i;
  bit m_txpd, m_rxpd, m_pll, m_ce, m_ant;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_slq <= 1; m_corr <= 0; m_i <= 0;
      m_txpd <= 1; m_rxpd <= 1; m_pll <= 1; m_ce <= 0; m_ant <= 0;
    end else begin
      m_slq  <= sys_load;
      m_act  <= sys_load && (m_act || !m_slq);
      m_ce   <= m_act;
      m_txpd <= !(m_act && tx_frame);
      m_rxpd <= !(m_act && rx_frame && !tx_frame);
      m_ant  <= m_act && tx_frame;
      if (!m_act) m_pll <= 1;
      else if (tx_frame) m_pll <= 1;
      else if (rx_frame) m_pll <= cfg_pll_open_rx;
      else m_pll <= 0;
      if (!m_act || corr_end) m_corr <= 0;
      else if (!m_corr && corr_start) begin m_corr <= 1; m_i <= 0; end
      else if (m_corr) m_i <= m_i + 1;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", "dcc_hold_n", dcc_hold_n, !m_corr);
      chk("R4", "dcc_lead_n", dcc_lead_n, !(m_corr && m_i < 120));
      chk("R5", "dcc_pwm_n", dcc_pwm_n, !(m_corr && (m_i < 120 || ((m_i - 120) % 8) == 0)));
      chk("R7", "tx_pd", tx_pd, m_txpd);
      chk("R8", "rx_pd", rx_pd, m_rxpd);
      chk("R9", "pll_pd", pll_pd, m_pll);
      chk("R2", "chip_en", chip_en, m_ce);
      chk("R2", "ref_osc_en", ref_osc_en, m_ce);
      chk("R10", "ant_sw", ant_sw, m_ant);
      chk("R10", "ant_sw_n", ant_sw_n, !m_ant);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    corr_start = 1; cyc(1); corr_start = 0;
  endtask

  task automatic pulse_end();
    corr_end = 1; cyc(1); corr_end = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; sys_load = 1; cfg_pll_open_rx = 0;
    tx_frame = 0; rx_frame = 0; corr_start = 0; corr_end = 0;
    cyc(3);
    rst_n = 1;
    cyc(4);
    // R1: reset state with sys_load already high, no start
    chk("R1", "chip_en", chip_en, 1'b0);
    chk("R1", "tx_pd", tx_pd, 1'b1);
    chk("R1", "pll_pd", pll_pd, 1'b1);
    chk("R1", "dcc_hold_n", dcc_hold_n, 1'b1);
    tx_frame = 1; cyc(3);
    chk("R1", "tx_pd idle", tx_pd, 1'b1);
    tx_frame = 0;
    pulse_start(); cyc(2);
    chk("R6", "dcc_hold_n idle start", dcc_hold_n, 1'b1);
    // R2: rising edge activates
    sys_load = 0; cyc(2);
    sys_load = 1; cyc(1);
    chk("R2", "chip_en one clock", chip_en, 1'b0);
    cyc(1);
    chk("R2", "chip_en", chip_en, 1'b1);
    chk("R2", "ref_osc_en", ref_osc_en, 1'b1);
    chk("R9", "pll_pd active no frame", pll_pd, 1'b0);
    // R7/R9/R10: transmit
    tx_frame = 1; cyc(4);
    chk("R7", "tx_pd tx", tx_pd, 1'b0);
    chk("R9", "pll_pd tx", pll_pd, 1'b1);
    chk("R10", "ant_sw tx", ant_sw, 1'b1);
    tx_frame = 0; cyc(1);
    // R8/R9: receive without and with loop-open
    rx_frame = 1; cyc(4);
    chk("R8", "rx_pd rx", rx_pd, 1'b0);
    chk("R9", "pll_pd rx cfg0", pll_pd, 1'b0);
    cfg_pll_open_rx = 1; cyc(3);
    chk("R9", "pll_pd rx cfg1", pll_pd, 1'b1);
    // R8: both requests, transmit wins
    tx_frame = 1; cyc(3);
    chk("R8", "rx_pd both", rx_pd, 1'b1);
    chk("R7", "tx_pd both", tx_pd, 1'b0);
    tx_frame = 0; rx_frame = 0; cfg_pll_open_rx = 0; cyc(2);
    // full correlation with solid window and pulsing
    pulse_start();
    cyc(119);
    chk("R4", "dcc_lead_n cycle 119", dcc_lead_n, 1'b0);
    cyc(1);
    chk("R4", "dcc_lead_n cycle 120", dcc_lead_n, 1'b1);
    chk("R5", "dcc_pwm_n cycle 120", dcc_pwm_n, 1'b0);
    cyc(1);
    chk("R5", "dcc_pwm_n cycle 121", dcc_pwm_n, 1'b1);
    cyc(7);
    chk("R5", "dcc_pwm_n cycle 128", dcc_pwm_n, 1'b0);
    cyc(40);
    pulse_start(); cyc(10);   // ignored restart, model keeps counting
    pulse_end();
    chk("R6", "dcc_hold_n after end", dcc_hold_n, 1'b1);
    chk("R6", "dcc_pwm_n after end", dcc_pwm_n, 1'b1);
    cyc(3);
    // early end inside the solid window
    pulse_start(); cyc(50);
    pulse_end();
    chk("R6", "dcc_lead_n early end", dcc_lead_n, 1'b1);
    chk("R6", "dcc_pwm_n early end", dcc_pwm_n, 1'b1);
    // start and end together
    corr_start = 1; corr_end = 1; cyc(1);
    corr_start = 0; corr_end = 0;
    chk("R6", "dcc_hold_n start+end", dcc_hold_n, 1'b1);
    cyc(2);
    // drop to idle during correlation and a receive frame
    rx_frame = 1;
    pulse_start(); cyc(20);
    sys_load = 0; cyc(3);
    chk("R2", "chip_en after drop", chip_en, 1'b0);
    chk("R6", "dcc_hold_n after drop", dcc_hold_n, 1'b1);
    chk("R8", "rx_pd after drop", rx_pd, 1'b1);
    rx_frame = 0; cyc(5);
    finish_run();
  end

endmodule